// File: doc/BRIEF.md
# Bit-Reversed Counter PWM DAC

This block produces a single pulse-width-modulated bit meant to feed an external RC lowpass filter, which turns it into an analog level. A free-running period counter advances on each step and a comparator drives the output high while the counter sits below a held duty value. Over every period of 2^WIDTH steps the output is therefore high for exactly `duty` steps, so the filtered level is proportional to `duty / 2^WIDTH`.

Two comparison modes exist. In linear mode the counter is compared as it is, which gives one contiguous pulse per period. In reversed mode the counter's bits are fed to the comparator in swapped end-to-end order. The number of high steps per period stays the same, but they are spread as evenly as possible through the period. This raises the pulse frequency and lowers the ripple the filter has to remove, at no cost beyond wiring. A step is an enabled clock (`tick_en` high) thinned by an optional divide-by-(PRESCALE+1) stage. Duty and mode are taken in only at the period boundary.

Top module: `bitrev_pwm_dac`

## Requirements
- R1: A clock edge with `rst` high clears the period counter, the prescaler, the held duty (to 0) and the held mode (to linear). It also drives `pwm_out` low. The output then stays low until the first wrap of the counter has loaded a nonzero duty.
- R2: A step occurs on a clock with `tick_en` high on which the prescaler has already counted PRESCALE enabled clocks since the last step. With PRESCALE=0 every enabled clock is a step. The period counter advances by one per step and holds on all other clocks.
- R3: In linear mode (`mode_rev`=0 held), the output for counter value k is high exactly when k < held duty. With WIDTH=4 and duty 5 the per-period pattern over k=0..15 is 16'h001F (bit k).
- R4: In reversed mode (`mode_rev`=1 held), the comparator sees counter bit i at position WIDTH-1-i. With WIDTH=4 and duty 8 the output alternates every step, pattern 16'h5555.
- R5: With duty 1, both modes give the same train: one high step per period, at counter value 0 (pattern 16'h0001 for WIDTH=4).
- R6: A held duty of 0 keeps `pwm_out` low in both modes.
- R7: In either mode, any window of 2^WIDTH consecutive steps with unchanged held values contains exactly `duty` high outputs.
- R8: `duty` and `mode_rev` are copied into the held registers only on the step that wraps the counter from all ones to zero. Changes at other times have no effect on the current period.
- R9: `pwm_out` is registered. It shows the comparison for the counter and held values of the previous clock, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Clock enable for the prescaler and period counter |
| mode_rev | input | 1 | 0 = linear comparison, 1 = bit-reversed comparison |
| duty | input | WIDTH | Number of high steps per period |
| pwm_out | output | 1 | Registered PWM bit to the external filter |

## Verification
A wrong counter or prescaler state moves the output pattern in time. Because the expected train is predicted cycle by cycle, such a fault shows up at `pwm_out` within one period. A wrong held duty or mode, or a load at the wrong moment, changes the count or spacing of high steps within the first period after the load. The fixed traces for duty 1, 5 and 8 catch a miswired bit reversal. The mid-period duty change shows any premature load on the following cycle.

// File: rtl/bitrev_pwm_pkg.sv
package bitrev_pwm_pkg;

  typedef enum logic {
    CMP_LINEAR   = 1'b0,
    CMP_REVERSED = 1'b1
  } cmp_mode_e;

endpackage

// File: rtl/bitrev_pwm_prescale.sv
module bitrev_pwm_prescale #(
  parameter int PRESCALE = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  output logic step
);

  generate
    if (PRESCALE == 0) begin : g_direct
      assign step = tick_en;
    end else begin : g_divide
      localparam int PW = $clog2(PRESCALE + 1);
      localparam logic [PW-1:0] LAST = PW'(PRESCALE);
      logic [PW-1:0] div_q;

      assign step = tick_en && (div_q == LAST);

      always_ff @(posedge clk) begin
        if (rst) begin
          div_q <= '0;
        end else if (tick_en) begin
          if (div_q == LAST) div_q <= '0;
          else               div_q <= div_q + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/bitrev_pwm_period.sv
module bitrev_pwm_period
  import bitrev_pwm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [WIDTH-1:0] duty,
  input  logic             mode_rev,
  output logic [WIDTH-1:0] cnt,
  output logic [WIDTH-1:0] duty_hold,
  output cmp_mode_e        mode_hold
);

  localparam logic [WIDTH-1:0] TOP = '1;

  logic at_wrap;
  assign at_wrap = step && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_hold <= '0;
      mode_hold <= CMP_LINEAR;
    end else if (at_wrap) begin
      duty_hold <= duty;
      mode_hold <= cmp_mode_e'(mode_rev);
    end
  end

endmodule

// File: rtl/bitrev_pwm_compare.sv
module bitrev_pwm_compare
  import bitrev_pwm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cnt,
  input  logic [WIDTH-1:0] duty_hold,
  input  cmp_mode_e        mode_hold,
  output logic             hit
);

  logic [WIDTH-1:0] swapped;
  logic [WIDTH-1:0] operand;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_swap
      assign swapped[WIDTH-1-i] = cnt[i];
    end
  endgenerate

  assign operand = (mode_hold == CMP_REVERSED) ? swapped : cnt;
  assign hit     = operand < duty_hold;

endmodule

// File: rtl/bitrev_pwm_dac.sv
module bitrev_pwm_dac
  import bitrev_pwm_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int PRESCALE = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             mode_rev,
  input  logic [WIDTH-1:0] duty,
  output logic             pwm_out
);

  logic             step;
  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] duty_hold;
  cmp_mode_e        mode_hold;
  logic             hit;

  bitrev_pwm_prescale #(.PRESCALE(PRESCALE)) u_prescale (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .step    (step)
  );

  bitrev_pwm_period #(.WIDTH(WIDTH)) u_period (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .duty      (duty),
    .mode_rev  (mode_rev),
    .cnt       (cnt),
    .duty_hold (duty_hold),
    .mode_hold (mode_hold)
  );

  bitrev_pwm_compare #(.WIDTH(WIDTH)) u_compare (
    .cnt       (cnt),
    .duty_hold (duty_hold),
    .mode_hold (mode_hold),
    .hit       (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= hit;
  end

endmodule

// File: rtl/bitrev_pwm_dac_chk.sv
module bitrev_pwm_dac_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             step,
  input logic [WIDTH-1:0] cnt,
  input logic [WIDTH-1:0] duty_hold,
  input logic             pwm_out
);

  localparam logic [WIDTH-1:0] TOP = '1;

  AST_RST_LOW: assert property (@(posedge clk) rst |=> !pwm_out); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt)); // R2

  AST_STEP_ADV: assert property (@(posedge clk) disable iff (rst)
    step |=> (cnt == WIDTH'($past(cnt) + 1'b1))); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !(step && cnt == TOP) |=> $stable(duty_hold)); // R8

  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
    (duty_hold == '0) |=> !pwm_out); // R6

endmodule

bind bitrev_pwm_dac bitrev_pwm_dac_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .step      (step),
  .cnt       (cnt),
  .duty_hold (duty_hold),
  .pwm_out   (pwm_out)
);

// File: tb/bitrev_pwm_dac_bench.sv
module bitrev_pwm_ref #(
  parameter int W = 4,
  parameter int P = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic         mode_rev,
  input  logic [W-1:0] duty,
  output logic         exp_pwm,
  output logic [W-1:0] m_cnt
);
  logic [W-1:0] m_hold;
  logic         m_mode;
  int           m_ps;
  logic [W-1:0] rv;
  logic         stp;

  always @(posedge clk) begin
    if (rst) begin
      exp_pwm <= 1'b0; m_cnt <= '0; m_hold <= '0; m_mode <= 1'b0; m_ps <= 0;
    end else begin
      for (int i = 0; i < W; i++) rv[W-1-i] = m_cnt[i];
      exp_pwm <= (m_mode ? rv : m_cnt) < m_hold;
      stp = tick_en && (m_ps == P);
      if (tick_en) m_ps <= (m_ps == P) ? 0 : m_ps + 1;
      if (stp) begin
        if (m_cnt == '1) begin m_hold <= duty; m_mode <= mode_rev; end
        m_cnt <= m_cnt + 1'b1;
      end
    end
  end
endmodule

module bitrev_pwm_dac_bench;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic mode_rev = 1'b0;
  logic [W-1:0] duty = '0;
  logic pwm_a, pwm_b, exp_a, exp_b;
  logic [W-1:0] mc_a, mc_b;

  int total = 0;
  int fails = 0;
  string cur_req = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  bitrev_pwm_dac #(.WIDTH(W), .PRESCALE(0)) u_bitrev_pwm_dac (
    .clk(clk), .rst(rst), .tick_en(tick_en), .mode_rev(mode_rev), .duty(duty), .pwm_out(pwm_a));
  bitrev_pwm_dac #(.WIDTH(W), .PRESCALE(2)) u_bitrev_pwm_dac_div (
    .clk(clk), .rst(rst), .tick_en(tick_en), .mode_rev(mode_rev), .duty(duty), .pwm_out(pwm_b));

  bitrev_pwm_ref #(.W(W), .P(0)) u_ref_a (
    .clk(clk), .rst(rst), .tick_en(tick_en), .mode_rev(mode_rev), .duty(duty), .exp_pwm(exp_a), .m_cnt(mc_a));
  bitrev_pwm_ref #(.W(W), .P(2)) u_ref_b (
    .clk(clk), .rst(rst), .tick_en(tick_en), .mode_rev(mode_rev), .duty(duty), .exp_pwm(exp_b), .m_cnt(mc_b));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the reference models (R9 latency built in)
  always @(negedge clk) begin
    if ($time > 0 && !done) begin
      check({cur_req, "/R9 main"}, 32'(pwm_a), 32'(exp_a));
      check("R2 prescaled", 32'(pwm_b), 32'(exp_b));
    end
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Align to the state where the counter has just wrapped, then record one period.
  task automatic grab(output logic [15:0] tr);
    while (mc_a != '0) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      tr[i] = pwm_a;
    end
  endtask

  function automatic int ones16(logic [15:0] v);
    int c = 0;
    for (int i = 0; i < 16; i++) c += v[i];
    return c;
  endfunction

  initial begin
    logic [15:0] tr, tr2;
    void'($urandom(32'd1234));
    run(3);
    check("R1 reset low", 32'(pwm_a), 32'd0);
    duty = 4'd5;
    @(negedge clk); rst = 1'b0; tick_en = 1'b1;
    cur_req = "R1";
    run(10);
    check("R1 low before first wrap", 32'(pwm_a), 32'd0);
    run(10);

    cur_req = "R3";
    grab(tr);
    check("R3 linear duty5 trace", 32'(tr), 32'h001F);
    check("R7 linear duty5 count", ones16(tr), 5);

    mode_rev = 1'b1; duty = 4'd8; cur_req = "R4";
    run(20);
    grab(tr);
    check("R4 reversed duty8 trace", 32'(tr), 32'h5555);
    check("R7 reversed duty8 count", ones16(tr), 8);

    duty = 4'd1; cur_req = "R5";
    run(20);
    grab(tr);
    mode_rev = 1'b0;
    run(20);
    grab(tr2);
    check("R5 duty1 reversed trace", 32'(tr), 32'h0001);
    check("R5 duty1 modes equal", 32'(tr2), 32'(tr));

    duty = 4'd0; mode_rev = 1'b1; cur_req = "R6";
    run(20);
    grab(tr);
    check("R6 duty0 reversed", 32'(tr), 32'h0);
    mode_rev = 1'b0;
    run(20);
    grab(tr);
    check("R6 duty0 linear", 32'(tr), 32'h0);

    duty = 4'd3; mode_rev = 1'b1; cur_req = "R8";
    run(20);
    while (mc_a != 4'd4) @(negedge clk);
    duty = 4'd15; mode_rev = 1'b0;
    run(1);
    duty = 4'd3; mode_rev = 1'b1;
    grab(tr);
    check("R8 mid-period change ignored", 32'(tr), 32'h0111);
    check("R7 reversed duty3 count", ones16(tr), 3);

    cur_req = "R2";
    for (int k = 0; k < 40; k++) begin
      duty = 4'($urandom_range(0, 15));
      mode_rev = 1'($urandom_range(0, 1));
      for (int c = 0; c < 50; c++) begin
        tick_en = ($urandom_range(0, 3) != 0);
        @(negedge clk);
      end
    end
    tick_en = 1'b0;
    run(5);
    check("R2 counter held when disabled", 32'(pwm_a), 32'(exp_a));

    cur_req = "R7";
    tick_en = 1'b1;
    for (int d = 0; d < 16; d++) begin
      duty = 4'(d); mode_rev = d[0];
      run(20);
      grab(tr);
      check("R7 high count per period", ones16(tr), d);
    end

    cur_req = "R1";
    rst = 1'b1;
    run(2);
    check("R1 reset again", 32'(pwm_a), 32'd0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule